// File: doc/BRIEF.md
# Greatest-Common-Divisor Accelerator with Message-Based Register Access

This block computes the greatest common divisor of two unsigned operands for a host that talks to it only through request and response messages. The host first writes operand A and operand B into two accelerator registers, then issues a read of the result register. That read is what starts the computation. The matching response is held back until the datapath has converged, and it carries the divisor.

Both channels use a valid/ready handshake. Each request carries an opaque tag, a read/write kind, a register index, a data word and an id. Every request gets exactly one response. The response repeats the opaque tag, the id and the kind of its request. The block keeps at most one transaction in flight: while a computation runs, or while a response waits to be taken, it accepts no new request.

The datapath subtracts the smaller value from the larger, one step per clock cycle, until the two values are equal. It does not use a divider, so the latency depends on the operands.

Top module: `gcd_xcel`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it is released, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request with `req_type` = 1 (write) and `req_addr` = 1 stores `req_data` as operand A. The same request with `req_addr` = 2 stores operand B.
- R3: Every accepted write produces one response with `rsp_type` = 1 and `rsp_data` = 0. That response is valid in the cycle after the accepting clock edge.
- R4: Every response returns the `req_opq` and `req_id` values of the request it answers.
- R5: An accepted read (`req_type` = 0) of register 0 starts a computation. Its response has `rsp_type` = 0 and `rsp_data` equal to the GCD of A and B. The GCD is found by repeatedly replacing the larger value with the difference of the two until they are equal.
- R6: If the computation needs S subtraction steps, the response to a read of register 0 becomes valid after the (S+1)th rising edge that follows the accepting edge.
- R7: After a request is accepted, `req_ready` stays 0 until its response has been accepted.
- R8: While `rsp_valid` = 1 and `rsp_ready` = 0, every response field stays unchanged.
- R9: A read of register 1 or 2 returns the stored operand one cycle after acceptance. A read of any register index above 2 returns 0. A write to register 0 or to any index above 2 is answered but changes no stored operand.
- R10: A computation leaves both stored operands unchanged, so a later read of register 1 or 2 returns the value last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_opq | input | OPQ_W | Opaque tag, echoed in the response |
| req_type | input | 1 | 0 = read, 1 = write |
| req_addr | input | ADDR_W | Accelerator register index |
| req_data | input | DATA_W | Write data |
| req_id | input | ID_W | Request id, echoed in the response |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_opq | output | OPQ_W | Echoed opaque tag |
| rsp_type | output | 1 | Echoed request kind |
| rsp_data | output | DATA_W | Read data or GCD result; 0 for writes |
| rsp_id | output | ID_W | Echoed request id |

## Verification
The bench builds the block with a 5-bit data width. At that width, every pair of nonzero operands from 1 to 31 can be swept. Each pair is checked for its result and also for its exact latency in cycles against a subtraction-step count that the bench computes itself. The extreme pairs, such as (31,1) with 30 steps and equal operands with none, are therefore covered completely. Directed sequences cover reads of the operand registers, writes to indices that store nothing, reads of unmapped indices, and a response held back by the host for several cycles.

// File: rtl/gcd_xcel_pkg.sv
package gcd_xcel_pkg;

  // message kind carried in the request/response type field
  typedef enum logic {
    MSG_RD = 1'b0,
    MSG_WR = 1'b1
  } msg_kind_e;

  // controller states
  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_CALC = 2'd1,
    CTL_RESP = 2'd2
  } ctl_state_e;

  // accelerator register indices
  localparam int unsigned RESULT_XR = 0;
  localparam int unsigned OPA_XR    = 1;
  localparam int unsigned OPB_XR    = 2;
  localparam int unsigned NUM_OPND  = 2;

endpackage

// File: rtl/gcd_req_decode.sv
module gcd_req_decode
  import gcd_xcel_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              fire,
  input  logic              kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_OPND-1:0] ld_opnd,
  output logic [NUM_OPND-1:0] rd_opnd,
  output logic              start,
  output logic              is_wr
);

  localparam logic [ADDR_W-1:0] RES_IDX = ADDR_W'(RESULT_XR);

  msg_kind_e k;
  assign k = msg_kind_e'(kind);

  assign is_wr = (k == MSG_WR);
  assign start = fire && (k == MSG_RD) && (addr == RES_IDX);

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(OPA_XR + i);
    assign ld_opnd[i] = fire && (k == MSG_WR) && (addr == IDX);
    assign rd_opnd[i] = (k == MSG_RD) && (addr == IDX);
  end

endmodule

// File: rtl/gcd_opnd_bank.sv
module gcd_opnd_bank
  import gcd_xcel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_OPND-1:0]              wr_en,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_OPND-1:0][DATA_W-1:0]  q
);

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_xr
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= '0;
      else if (wr_en[i]) q[i] <= wr_data;
    end

    // R10
    opnd_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en[i] |=> q[i] == $past(q[i]));
  end

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_en) <= 1);

endmodule

// File: rtl/gcd_sub_core.sv
module gcd_sub_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic              equal,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] a_q, b_q;
  logic [DATA_W:0]   sum_w;

  assign equal  = (a_q == b_q);
  assign result = a_q;
  assign sum_w  = {1'b0, a_q} + {1'b0, b_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= b_in;
    end else if (run && !equal) begin
      if (a_q > b_q) a_q <= a_q - b_q;
      else           b_q <= b_q - a_q;
    end
  end

  // R5
  core_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (a_q == $past(a_in)) && (b_q == $past(b_in)));

  // R6
  step_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    run && !load && !equal |=> sum_w < $past(sum_w));

  // R5
  no_load_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && run));

endmodule

// File: rtl/gcd_rsp_reg.sv
module gcd_rsp_reg #(
  parameter int OPQ_W  = 8,
  parameter int ID_W   = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_ld,
  input  logic [OPQ_W-1:0]  in_opq,
  input  logic              in_kind,
  input  logic [ID_W-1:0]   in_id,
  input  logic              data_ld,
  input  logic [DATA_W-1:0] in_data,
  input  logic              raise,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [OPQ_W-1:0]  rsp_opq,
  output logic              rsp_type,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ID_W-1:0]   rsp_id
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_opq   <= '0;
      rsp_type  <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else begin
      if (hdr_ld) begin
        rsp_opq  <= in_opq;
        rsp_type <= in_kind;
        rsp_id   <= in_id;
      end
      if (data_ld) rsp_data <= in_data;
      if (raise)          rsp_valid <= 1'b1;
      else if (rsp_ready) rsp_valid <= 1'b0;
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
      $stable(rsp_opq) && $stable(rsp_id) && $stable(rsp_type));

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !hdr_ld && !data_ld && !raise);

endmodule

// File: rtl/gcd_xcel.sv
module gcd_xcel
  import gcd_xcel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int OPQ_W  = 8,
  parameter int ID_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OPQ_W-1:0]  req_opq,
  input  logic              req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [OPQ_W-1:0]  rsp_opq,
  output logic              rsp_type,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ID_W-1:0]   rsp_id
);

  ctl_state_e state_q, state_d;

  logic                            fire;
  logic [NUM_OPND-1:0]             ld_opnd, rd_opnd;
  logic                            start, is_wr;
  logic [NUM_OPND-1:0][DATA_W-1:0] opnd;
  logic                            core_equal;
  logic [DATA_W-1:0]               core_result;
  logic                            calc_done;
  logic                            data_ld, raise;
  logic [DATA_W-1:0]               data_sel, rd_val;

  assign req_ready = (state_q == CTL_IDLE);
  assign fire      = req_valid && req_ready;

  gcd_req_decode #(.ADDR_W(ADDR_W)) u_dec (
    .fire    (fire),
    .kind    (req_type),
    .addr    (req_addr),
    .ld_opnd (ld_opnd),
    .rd_opnd (rd_opnd),
    .start   (start),
    .is_wr   (is_wr)
  );

  gcd_opnd_bank #(.DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ld_opnd),
    .wr_data (req_data),
    .q       (opnd)
  );

  gcd_sub_core #(.DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .run    (state_q == CTL_CALC),
    .a_in   (opnd[0]),
    .b_in   (opnd[1]),
    .equal  (core_equal),
    .result (core_result)
  );

  // read data for non-starting reads: selected operand, else zero
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_OPND; i++)
      if (rd_opnd[i]) rd_val = opnd[i];
  end

  assign calc_done = (state_q == CTL_CALC) && core_equal;
  assign raise     = (fire && !start) || calc_done;
  assign data_ld   = raise;
  assign data_sel  = calc_done ? core_result : (is_wr ? '0 : rd_val);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CTL_IDLE: if (fire) state_d = start ? CTL_CALC : CTL_RESP;
      CTL_CALC: if (core_equal) state_d = CTL_RESP;
      CTL_RESP: if (rsp_ready) state_d = CTL_IDLE;
      default:  state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= CTL_IDLE;
    else     state_q <= state_d;
  end

  gcd_rsp_reg #(.OPQ_W(OPQ_W), .ID_W(ID_W), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .hdr_ld    (fire),
    .in_opq    (req_opq),
    .in_kind   (req_type),
    .in_id     (req_id),
    .data_ld   (data_ld),
    .in_data   (data_sel),
    .raise     (raise),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_opq   (rsp_opq),
    .rsp_type  (rsp_type),
    .rsp_data  (rsp_data),
    .rsp_id    (rsp_id)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> req_ready && !rsp_valid);

  // R7
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  // R3
  wr_rsp_next_chk: assert property (@(posedge clk) disable iff (rst)
    fire && (req_type == MSG_WR) |=> rsp_valid && (rsp_type == MSG_WR) && (rsp_data == '0));

  // R4
  echo_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !start |=> (rsp_opq == $past(req_opq)) && (rsp_id == $past(req_id)));

  // R5
  start_waits_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !rsp_valid && !req_ready);

endmodule

// File: tb/gcd_xcel_test.sv
`timescale 1ns/1ps
module gcd_xcel_test;

  localparam int DW = 5;
  localparam int AW = 5;
  localparam int OW = 8;
  localparam int IW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [OW-1:0] req_opq = '0;
  logic          req_type = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [IW-1:0] req_id = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [OW-1:0] rsp_opq;
  logic          rsp_type;
  logic [DW-1:0] rsp_data;
  logic [IW-1:0] rsp_id;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gcd_xcel #(.DATA_W(DW), .ADDR_W(AW), .OPQ_W(OW), .ID_W(IW)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_opq(req_opq),
    .req_type(req_type), .req_addr(req_addr), .req_data(req_data), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_opq(rsp_opq),
    .rsp_type(rsp_type), .rsp_data(rsp_data), .rsp_id(rsp_id)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gcd_ref(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  function automatic int sub_steps(input int a, input int b);
    int n = 0;
    while (a != b) begin
      if (a > b) a = a - b; else b = b - a;
      n++;
    end
    return n;
  endfunction

  // one full transaction; hold = extra cycles the response is refused
  task automatic xact(input int typ, input int addr, input int data,
                      input int exp_data, input int exp_cnt, input int hold,
                      input string tag);
    int cnt;
    int busy_seen;
    logic [OW-1:0] opq;
    logic [IW-1:0] id;
    opq = OW'(addr * 37 + data * 5 + 3);
    id  = IW'(data * 11 + addr * 97 + 1);
    @(negedge clk);
    req_opq = opq; req_type = typ[0]; req_addr = AW'(addr);
    req_data = DW'(data); req_id = id; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1;
    busy_seen = 0;
    while (!rsp_valid && cnt < 200) begin
      if (req_ready) busy_seen = 1;
      @(negedge clk);
      cnt++;
    end
    check({tag, " R7 ready low while busy"}, busy_seen, 0);
    check({tag, " R6/R3 latency"}, cnt, exp_cnt);
    check({tag, " R5/R9 data"}, int'(rsp_data), exp_data);
    check({tag, " R4 opaque"}, int'(rsp_opq), int'(opq));
    check({tag, " R4 id"}, int'(rsp_id), int'(id));
    check({tag, " R3/R5 type"}, int'(rsp_type), typ);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check({tag, " R8 valid held"}, int'(rsp_valid), 1);
      check({tag, " R8 data held"}, int'(rsp_data), exp_data);
      check({tag, " R8 id held"}, int'(rsp_id), int'(id));
      check({tag, " R7 ready low on hold"}, int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " R7 ready after take"}, int'(req_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(req_ready), 1);
    check("R1 valid in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 valid after reset", int'(rsp_valid), 0);

    // directed: operand store and read back
    xact(1, 1, 18, 0, 1, 0, "R2 write A");
    xact(1, 2, 12, 0, 1, 0, "R2 write B");
    xact(0, 1, 0, 18, 1, 0, "R9 read A");
    xact(0, 2, 0, 12, 1, 0, "R9 read B");
    // ignored writes
    xact(1, 0, 7, 0, 1, 0, "R9 write idx0");
    xact(1, 3, 9, 0, 1, 0, "R9 write idx3");
    xact(1, 31, 9, 0, 1, 0, "R9 write idx31");
    xact(0, 1, 0, 18, 1, 0, "R9 A kept");
    xact(0, 2, 0, 12, 1, 0, "R9 B kept");
    xact(0, 5, 0, 0, 1, 0, "R9 unmapped read");
    // compute with held response
    xact(0, 0, 0, 6, sub_steps(18, 12) + 2, 3, "R5 gcd 18,12 held");
    xact(0, 1, 0, 18, 1, 0, "R10 A after compute");
    xact(0, 2, 0, 12, 1, 0, "R10 B after compute");
    xact(1, 2, 5, 0, 1, 2, "R8 write rsp held");

    // sweep of every nonzero operand pair
    for (int a = 1; a < (1 << DW); a++) begin
      for (int b = 1; b < (1 << DW); b++) begin
        xact(1, 1, a, 0, 1, 0, "R3 sweep write A");
        xact(1, 2, b, 0, 1, 0, "R3 sweep write B");
        xact(0, 0, 0, gcd_ref(a, b), sub_steps(a, b) + 2, 0, "R5 sweep gcd");
        if (a == b) xact(0, 1, 0, a, 1, 0, "R10 sweep A kept");
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule